// File: doc/BRIEF.md
# Multi-FIFO Interleaved Address Sequencer

This block produces the peripheral-side address stream for one DMA channel that moves multichannel audio between a linear memory buffer and a peripheral with a row of FIFO data registers. It does not use one fixed register address. It stays on a FIFO register for a programmed number of words and then steps to the next register. The step between registers can be set to skip a number of unused words. After the last register it returns to the first.

Two complete settings are held, one for record (peripheral to memory) and one for playback (memory to peripheral). A direction input picks which setting drives the sequence. The sequence advances once per completed word handshake. A one-cycle frame pulse marks the word that closes a full pass over all FIFOs.

Top module: `mfifo_addr_seq`

## Requirements
- R1: While `rstN` is low and right after reset, `fifoIdx` is 0, `frameDone` is 0, both direction settings hold base 0, count 0, stride 0 and words 0, and `fifoAddr` is 0.
- R2: `fifoAddr` equals 4 × ((base + fifoIdx × (stride + 1)) mod 2^ADDR_W). The base, stride and FIFO count come from the setting picked by `dirSel`. `fifoAddr` is a byte address with 4-byte words.
- R3: A word handshake is a cycle in which `req` and `ack` are both high. With no handshake and no clear, `fifoIdx` and `fifoAddr` keep their values at the next edge. A lone `req` or a lone `ack` has no effect.
- R4: The sequencer stays on one FIFO for exactly `words` handshakes and moves to the next FIFO on the handshake after that.
- R5: The handshake that moves off the last FIFO (index count−1) with its last word sets `fifoIdx` back to 0.
- R6: `frameDone` is high, combinationally, in exactly the handshake cycle that moves the last word of the last FIFO. It is low in every other cycle.
- R7: `cfgWe` loads base, count, stride and words into the setting picked by `cfgSel` (0 = record, 1 = playback). The other setting is left unchanged. `dirSel` (0 = record, 1 = playback) picks the active setting.
- R8: A `cfgWe` or `restart` cycle sets the FIFO index and the word position to 0. This takes priority over a handshake in the same cycle, and `frameDone` stays low in that cycle.
- R9: A FIFO count of 0 acts as 1, and a words value of 0 acts as 1. In both cases every handshake still advances the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Restart the sequence from FIFO 0 |
| cfgWe | input | 1 | Write one direction setting |
| cfgSel | input | 1 | Setting to write: 0 record, 1 playback |
| cfgBase | input | ADDR_W | Word address of FIFO 0 |
| cfgFifoCnt | input | CNT_W | Number of FIFO registers |
| cfgStride | input | STR_W | Unused words between adjacent FIFOs |
| cfgWords | input | WPF_W | Words moved per FIFO before stepping |
| dirSel | input | 1 | Active setting: 0 record, 1 playback |
| req | input | 1 | Word request |
| ack | input | 1 | Word acknowledge |
| fifoAddr | output | ADDR_W+2 | Current FIFO register byte address |
| fifoIdx | output | CNT_W | Current FIFO index |
| frameDone | output | 1 | Last word of a full pass |

## Verification
`frameDone` is a combinational result of the handshake inputs. The bench therefore reads it in the handshake cycle itself, one nanosecond after the inputs are driven on the falling edge. `fifoIdx` and `fifoAddr` come from registers that update on the rising edge inside that handshake cycle. The bench reads them at the next falling edge, once the inputs are released. A reference model inside the bench gives the expected index and address after every handshake. Clear and hold cases are checked on the same schedule.

// File: rtl/mfseq_pkg.sv
package mfseq_pkg;
  // Strobes from control to datapath, at most one active per cycle.
  typedef struct packed {
    logic clear;     // restart or configuration write
    logic stepWord;  // next word, same FIFO
    logic stepFifo;  // first word of next FIFO
    logic wrap;      // back to FIFO 0 after a full pass
  } seqStrobe_t;
endpackage

// File: rtl/mfseq_ctrl.sv
module mfseq_ctrl
  import mfseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       ack,
  input  logic       restart,
  input  logic       cfgWe,
  input  logic       lastWord,
  input  logic       lastFifo,
  output seqStrobe_t stb,
  output logic       frameDone
);
  logic hs;
  logic clr;

  assign hs  = req & ack;
  assign clr = restart | cfgWe;

  always_comb begin
    stb          = '0;
    stb.clear    = clr;
    stb.stepWord = hs & ~clr & ~lastWord;
    stb.stepFifo = hs & ~clr & lastWord & ~lastFifo;
    stb.wrap     = hs & ~clr & lastWord & lastFifo;
  end

  assign frameDone = stb.wrap;

  AST_FRAME_NEEDS_HS: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (req && ack && !restart && !cfgWe)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.stepWord, stb.stepFifo, stb.wrap})); // R8
endmodule

// File: rtl/mfseq_dp.sv
module mfseq_dp
  import mfseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int STR_W  = 2,
  parameter int WPF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgFifoCnt,
  input  logic [STR_W-1:0]  cfgStride,
  input  logic [WPF_W-1:0]  cfgWords,
  input  logic              dirSel,
  input  seqStrobe_t        stb,
  output logic              lastWord,
  output logic              lastFifo,
  output logic [CNT_W-1:0]  fifoIdx,
  output logic [ADDR_W+1:0] fifoAddr
);
  localparam int NDIR = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [STR_W-1:0]  stride;
    logic [WPF_W-1:0]  words;
  } dirCfg_t;

  dirCfg_t          cfgR [NDIR];
  logic [CNT_W-1:0] effCnt [NDIR];
  logic [WPF_W-1:0] effWords [NDIR];
  logic [WPF_W-1:0] wordPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < NDIR; d++) cfgR[d] <= '0;
    end else if (cfgWe) begin
      cfgR[cfgSel] <= '{base: cfgBase, cnt: cfgFifoCnt, stride: cfgStride, words: cfgWords};
    end
  end

  // Zero counts are read as one so that every handshake advances.
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign effCnt[d]   = (cfgR[d].cnt == '0)   ? CNT_W'(1) : cfgR[d].cnt;
    assign effWords[d] = (cfgR[d].words == '0) ? WPF_W'(1) : cfgR[d].words;
  end

  logic [CNT_W-1:0]  aCnt;
  logic [WPF_W-1:0]  aWords;
  logic [ADDR_W-1:0] aBase;
  logic [ADDR_W-1:0] pitch;
  logic [ADDR_W-1:0] offs;

  assign aCnt     = effCnt[dirSel];
  assign aWords   = effWords[dirSel];
  assign aBase    = cfgR[dirSel].base;
  assign pitch    = ADDR_W'(cfgR[dirSel].stride) + ADDR_W'(1);
  assign offs     = ADDR_W'(fifoIdx) * pitch;
  assign fifoAddr = {aBase + offs, 2'b00};

  assign lastWord = (wordPos >= aWords - WPF_W'(1));
  assign lastFifo = (fifoIdx >= aCnt - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear || stb.wrap) begin
      fifoIdx <= '0;
      wordPos <= '0;
    end else if (stb.stepFifo) begin
      fifoIdx <= fifoIdx + CNT_W'(1);
      wordPos <= '0;
    end else if (stb.stepWord) begin
      wordPos <= wordPos + WPF_W'(1);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> ($stable(fifoIdx) && $stable(wordPos))); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrap |=> (fifoIdx == '0 && wordPos == '0)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (fifoIdx == '0 && wordPos == '0)); // R8
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWord |=> ($stable(fifoIdx) && wordPos == $past(wordPos) + WPF_W'(1))); // R4
  AST_FIFO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepFifo |=> (fifoIdx == $past(fifoIdx) + CNT_W'(1) && wordPos == '0)); // R4
endmodule

// File: rtl/mfifo_addr_seq.sv
module mfifo_addr_seq
  import mfseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  parameter int STR_W  = 2,
  parameter int WPF_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgFifoCnt,
  input  logic [STR_W-1:0]  cfgStride,
  input  logic [WPF_W-1:0]  cfgWords,
  input  logic              dirSel,
  input  logic              req,
  input  logic              ack,
  output logic [ADDR_W+1:0] fifoAddr,
  output logic [CNT_W-1:0]  fifoIdx,
  output logic              frameDone
);
  seqStrobe_t stb;
  logic       lastWord;
  logic       lastFifo;

  mfseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .ack(ack), .restart(restart),
    .cfgWe(cfgWe), .lastWord(lastWord), .lastFifo(lastFifo),
    .stb(stb), .frameDone(frameDone)
  );

  mfseq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STR_W(STR_W), .WPF_W(WPF_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgBase(cfgBase),
    .cfgFifoCnt(cfgFifoCnt), .cfgStride(cfgStride), .cfgWords(cfgWords),
    .dirSel(dirSel), .stb(stb), .lastWord(lastWord), .lastFifo(lastFifo),
    .fifoIdx(fifoIdx), .fifoAddr(fifoAddr)
  );

  AST_FRAME_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (fifoIdx == '0)); // R6
endmodule

// File: tb/test_mfifo_addr_seq.sv
`timescale 1ns/1ps
module test_mfifo_addr_seq;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 4;
  localparam int STR_W  = 2;
  localparam int WPF_W  = 4;
  localparam int NVEC   = 4;

  // Vector table: dir, base, count, stride, words, handshakes, final index, frames
  localparam int V_DIR   [NVEC] = '{0, 1, 0, 1};
  localparam int V_BASE  [NVEC] = '{'h100, 'h200, 'h040, 'hFFF0};
  localparam int V_CNT   [NVEC] = '{4, 3, 2, 8};
  localparam int V_STR   [NVEC] = '{0, 1, 3, 1};
  localparam int V_WPF   [NVEC] = '{2, 1, 3, 1};
  localparam int V_STEPS [NVEC] = '{8, 5, 7, 9};
  localparam int V_FIDX  [NVEC] = '{0, 2, 0, 1};
  localparam int V_FRM   [NVEC] = '{1, 1, 1, 1};

  logic clk = 0;
  logic rstN = 0;
  logic restart = 0, cfgWe = 0, cfgSel = 0, dirSel = 0, req = 0, ack = 0;
  logic [ADDR_W-1:0] cfgBase = '0;
  logic [CNT_W-1:0]  cfgFifoCnt = '0;
  logic [STR_W-1:0]  cfgStride = '0;
  logic [WPF_W-1:0]  cfgWords = '0;
  logic [ADDR_W+1:0] fifoAddr;
  logic [CNT_W-1:0]  fifoIdx;
  logic              frameDone;

  always #2.5 clk = ~clk;

  mfifo_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STR_W(STR_W), .WPF_W(WPF_W)) i_mfifo_addr_seq (
    .clk(clk), .rstN(rstN), .restart(restart), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgBase(cfgBase), .cfgFifoCnt(cfgFifoCnt), .cfgStride(cfgStride),
    .cfgWords(cfgWords), .dirSel(dirSel), .req(req), .ack(ack),
    .fifoAddr(fifoAddr), .fifoIdx(fifoIdx), .frameDone(frameDone)
  );

  int nChk = 0, nBad = 0, frames = 0;
  bit done = 0;
  int mBase [2] = '{0, 0};
  int mCnt  [2] = '{1, 1};
  int mStr  [2] = '{0, 0};
  int mWpf  [2] = '{1, 1};
  int mIdx = 0, mW = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint expAddr();
    int d = int'(dirSel);
    return longint'(((mBase[d] + mIdx * (mStr[d] + 1)) % 65536) * 4);
  endfunction

  task automatic checkState(input string tag);
    chk({tag, " idx"}, fifoIdx, mIdx);
    chk({tag, " addr"}, fifoAddr, expAddr());
  endtask

  task automatic writeCfg(input int sel, input int b, input int c, input int s, input int w);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel[0]; cfgBase = b[ADDR_W-1:0];
    cfgFifoCnt = c[CNT_W-1:0]; cfgStride = s[STR_W-1:0]; cfgWords = w[WPF_W-1:0];
    @(negedge clk);
    cfgWe = 0;
    mBase[sel] = b; mCnt[sel] = (c == 0) ? 1 : c; mStr[sel] = s; mWpf[sel] = (w == 0) ? 1 : w;
    mIdx = 0; mW = 0;
  endtask

  task automatic doRestart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    mIdx = 0; mW = 0;
  endtask

  // One handshake cycle: frameDone read in that cycle, state at next falling edge.
  task automatic handshake(input string tag);
    int d = int'(dirSel);
    logic expF;
    expF = (mW == mWpf[d] - 1) && (mIdx == mCnt[d] - 1);
    @(negedge clk); req = 1; ack = 1;
    #1 chk({tag, " R6 frameDone"}, frameDone, expF);
    if (frameDone) frames++;
    @(negedge clk); req = 0; ack = 0;
    if (mW < mWpf[d] - 1) mW++;
    else begin
      mW = 0;
      mIdx = (mIdx < mCnt[d] - 1) ? mIdx + 1 : 0;
    end
    #1 checkState({tag, " R2/R4/R5"});
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    chk("R1 idx in reset", fifoIdx, 0);
    chk("R1 frame in reset", frameDone, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 addr after reset", fifoAddr, 0);
    chk("R1 idx after reset", fifoIdx, 0);

    // Vector table walk (R2, R4, R5, R6, R7)
    for (int v = 0; v < NVEC; v++) begin
      writeCfg(V_DIR[v], V_BASE[v], V_CNT[v], V_STR[v], V_WPF[v]);
      dirSel = V_DIR[v][0];
      doRestart();
      #1 checkState("R7 after select");
      frames = 0;
      for (int s = 0; s < V_STEPS[v]; s++) handshake($sformatf("vec%0d step%0d", v, s));
      chk($sformatf("R5 vec%0d final idx", v), fifoIdx, V_FIDX[v]);
      chk($sformatf("R6 vec%0d frames", v), frames, V_FRM[v]);
    end

    // R7: record setting survives playback writes
    dirSel = 0;
    writeCfg(0, 'h300, 2, 1, 1);
    writeCfg(1, 'h500, 3, 0, 1);
    handshake("R7 record after playback write");
    chk("R7 record base kept", fifoAddr, ('h300 + 2) * 4);

    // R3: lone req, lone ack
    doRestart();
    handshake("R3 pre");
    @(negedge clk); req = 1; ack = 0;
    @(negedge clk); req = 0; ack = 1;
    @(negedge clk); ack = 0;
    #1 checkState("R3 no handshake hold");

    // R8: clear wins over a simultaneous final handshake
    writeCfg(0, 'h080, 2, 0, 1);
    handshake("R8 pre");
    @(negedge clk); req = 1; ack = 1; restart = 1;
    #1 chk("R8 frameDone masked", frameDone, 0);
    @(negedge clk); req = 0; ack = 0; restart = 0;
    mIdx = 0; mW = 0;
    #1 checkState("R8 cleared");
    handshake("R8 post");
    @(negedge clk); req = 1; ack = 1; cfgWe = 1; cfgSel = 0;
    cfgBase = 16'h080; cfgFifoCnt = 4'd2; cfgStride = '0; cfgWords = 4'd1;
    #1 chk("R8 cfg masks frame", frameDone, 0);
    @(negedge clk); req = 0; ack = 0; cfgWe = 0;
    mIdx = 0; mW = 0;
    #1 checkState("R8 cfg cleared");

    // R9: zero count and zero words act as one
    writeCfg(0, 'h010, 0, 0, 0);
    for (int s = 0; s < 3; s++) handshake($sformatf("R9 zero cfg %0d", s));
    @(negedge clk);
    chk("R9/R6 frame low when idle", frameDone, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule